// File: doc/BRIEF.md
# SPI Controller Interrupt and FIFO Status Block

This block is the register-side status logic of an SPI controller. It gathers four event sources into a seven-bit status word. Two of them are latched events: a mode-fault pulse, and the moment the transmit FIFO level falls below a programmable watermark. The other two follow the FIFOs live: transmit FIFO full and receive FIFO not empty. A seven-bit interrupt mask gates the status word onto a single interrupt line.

Software never writes the mask directly. One register sets mask bits where ones are written, and another clears them. A third, read-only address shows the resulting mask. The latched status bits are cleared by writing ones back to the status address. A read of the receive-data address produces a one-cycle pop strobe towards the receive FIFO, which lives outside this block together with the serial engine.

Top module: `spi_irq_status`

## Requirements
- R1: After reset the mask is 0, the latched status bits are 0, the watermark is 1 and `irq` is low.
- R2: A write to offset 0x08 sets every mask bit whose written bit is 1 and leaves the others unchanged; reading 0x08 returns zero.
- R3: A write to offset 0x0C clears every mask bit whose written bit is 1 and leaves the others unchanged; reading 0x0C returns zero.
- R4: A read of offset 0x10 returns the current mask in bits 6:0, with all upper bits zero.
- R5: Status bit 1 (offset 0x04) latches on a rising edge of `mode_fault`. Holding `mode_fault` high does not latch it again.
- R6: Status bit 2 latches on the cycle where `tx_level < watermark` goes from false to true. A level equal to the watermark does not count as below it.
- R7: Status bit 3 follows `tx_full` and bit 4 follows `rx_nonempty` live. Bits 0, 5, 6 and all upper bits read zero.
- R8: A write to offset 0x04 clears each latched status bit (1 and 2) whose written bit is 1. The live bits 3 and 4 are unaffected.
- R9: If a latched status bit is set and cleared in the same cycle, it ends up set.
- R10: `irq` is high exactly when some status bit and the matching mask bit are both 1.
- R11: The watermark register at offset 0x28 is writable and reads back its LVL_W-bit value; it resets to 1.
- R12: A read of offset 0x20 drives `rx_pop` high in that same cycle and returns zero here. `rx_pop` is low in every other cycle, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the address |
| rx_pop | output | 1 | One-cycle pop request to the receive FIFO |
| tx_level | input | LVL_W | Current transmit FIFO fill level (0 to 128) |
| tx_full | input | 1 | Transmit FIFO full |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| mode_fault | input | 1 | Mode-fault indication from the serial engine |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with its defaults: 32-bit data, 6-bit offsets and an 8-bit level that covers the full 128-entry FIFO range. With these values the watermark can be moved away from its reset value of 1, up to 16, so the overwater edge is exercised both at a mid-range threshold and at the boundary where the level equals the watermark. The full 32-bit read path also makes the zero upper bits observable.

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 6,
  parameter int LVL_W    = 8,
  parameter int WM_RESET = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rx_pop,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic              tx_full,
  input  logic              rx_nonempty,
  input  logic              mode_fault,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_WM   = ADDR_W'(8'h28);

  logic [6:0]       mask_q;
  logic [LVL_W-1:0] wm_q;
  logic             mf_q, ow_q, mf_in_q, below_q;
  logic             below, mf_set, ow_set;
  logic [6:0]       clr, status;

  assign below  = tx_level < wm_q;
  assign mf_set = mode_fault & ~mf_in_q;
  assign ow_set = below & ~below_q;
  assign clr    = (reg_wr && reg_addr == A_STAT) ? reg_wdata[6:0] : 7'd0;
  assign status = {2'b00, rx_nonempty, tx_full, ow_q, mf_q, 1'b0};
  assign irq    = |(status & mask_q);
  assign rx_pop = reg_rd && reg_addr == A_RXD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      wm_q    <= LVL_W'(WM_RESET);
      mf_q    <= 1'b0;
      ow_q    <= 1'b0;
      mf_in_q <= 1'b0;
      below_q <= 1'b1;
    end else begin
      mf_in_q <= mode_fault;
      below_q <= below;
      mf_q    <= mf_set | (mf_q & ~clr[1]);
      ow_q    <= ow_set | (ow_q & ~clr[2]);
      if (reg_wr && reg_addr == A_SET)  mask_q <= mask_q | reg_wdata[6:0];
      if (reg_wr && reg_addr == A_CLR)  mask_q <= mask_q & ~reg_wdata[6:0];
      if (reg_wr && reg_addr == A_WM)   wm_q   <= reg_wdata[LVL_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = DATA_W'(status);
      A_MASK:  reg_rdata = DATA_W'(mask_q);
      A_WM:    reg_rdata = DATA_W'(wm_q);
      default: reg_rdata = '0;
    endcase
  end

  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_SET) |=> ((mask_q & $past(reg_wdata[6:0])) == $past(reg_wdata[6:0])));

  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CLR) |=> ((mask_q & $past(reg_wdata[6:0])) == 7'd0));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_set && clr[1]) |=> mf_q);

  assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[2] && !ow_set) |=> !ow_q);

  assert_no_irq_unmasked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 7'd0) |-> !irq);

  assert_held_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fault && $past(mode_fault) && clr[1]) |=> !mf_q);
endmodule

// File: tb/tb_spi_irq_status.sv
module tb_spi_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;
  // row: wr(1) addr(6) data(8) level(8) full(1) rxne(1) expected(8)
  localparam logic [32:0] TBL [NV] = '{
    {1'b0, 6'h10, 8'h00, 8'd5,  1'b0, 1'b0, 8'h00}, // R1 mask reset
    {1'b0, 6'h28, 8'h00, 8'd5,  1'b0, 1'b0, 8'h01}, // R1 R11 watermark reset
    {1'b1, 6'h08, 8'h16, 8'd5,  1'b0, 1'b0, 8'h00},
    {1'b0, 6'h10, 8'h00, 8'd5,  1'b0, 1'b0, 8'h16}, // R2 R4
    {1'b0, 6'h08, 8'h00, 8'd5,  1'b0, 1'b0, 8'h00}, // R2 reads zero
    {1'b1, 6'h0C, 8'h04, 8'd5,  1'b0, 1'b0, 8'h00},
    {1'b0, 6'h10, 8'h00, 8'd5,  1'b0, 1'b0, 8'h12}, // R3
    {1'b0, 6'h0C, 8'h00, 8'd5,  1'b0, 1'b0, 8'h00}, // R3 reads zero
    {1'b0, 6'h04, 8'h00, 8'd5,  1'b1, 1'b1, 8'h18}, // R7 live bits
    {1'b1, 6'h04, 8'h7F, 8'd5,  1'b1, 1'b1, 8'h00},
    {1'b0, 6'h04, 8'h00, 8'd5,  1'b1, 1'b1, 8'h18}, // R8 live bits survive
    {1'b1, 6'h28, 8'h10, 8'd31, 1'b0, 1'b0, 8'h00},
    {1'b0, 6'h28, 8'h00, 8'd31, 1'b0, 1'b0, 8'h10}, // R11
    {1'b0, 6'h04, 8'h00, 8'd15, 1'b0, 1'b0, 8'h00}, // R6 before edge
    {1'b0, 6'h04, 8'h00, 8'd15, 1'b0, 1'b0, 8'h04}, // R6 latched
    {1'b1, 6'h04, 8'h04, 8'd15, 1'b0, 1'b0, 8'h00},
    {1'b0, 6'h04, 8'h00, 8'd15, 1'b0, 1'b0, 8'h00}, // R8 cleared
    {1'b0, 6'h20, 8'h00, 8'd15, 1'b0, 1'b0, 8'h00}, // R12
    {1'b0, 6'h18, 8'h00, 8'd15, 1'b0, 1'b0, 8'h00}, // R12 unmapped
    {1'b1, 6'h08, 8'h7F, 8'd15, 1'b0, 1'b0, 8'h00},
    {1'b0, 6'h10, 8'h00, 8'd15, 1'b0, 1'b0, 8'h7F}  // R2 R4
  };

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0] tx_level = 8'd5;
  logic tx_full = 1'b0, rx_nonempty = 1'b0, mode_fault = 1'b0;
  logic rx_pop, irq;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_status dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_pop(rx_pop), .tx_level(tx_level), .tx_full(tx_full),
    .rx_nonempty(rx_nonempty), .mode_fault(mode_fault), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at posedge+1, observe at negedge, finish at next posedge+1
  task automatic op(input logic wr, input logic [5:0] a, input logic [7:0] d,
                    input logic do_chk, input logic [7:0] exp, input string tag);
    reg_wr = wr; reg_rd = ~wr; reg_addr = a; reg_wdata = {24'd0, d};
    @(negedge clk);
    if (do_chk) chk(tag, reg_rdata, {24'd0, exp});
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic idle();
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 6'h3C;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R12 rx_pop idle", {31'd0, rx_pop}, 32'd0);
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      tx_level    = TBL[i][17:10];
      tx_full     = TBL[i][9];
      rx_nonempty = TBL[i][8];
      op(TBL[i][32], TBL[i][31:26], TBL[i][25:18], ~TBL[i][32], TBL[i][7:0],
         $sformatf("table row %0d", i));
    end

    // R6 boundary with watermark 1
    tx_level = 8'd5;
    op(1'b1, 6'h28, 8'h01, 1'b0, 8'h00, "");
    op(1'b1, 6'h04, 8'h7F, 1'b0, 8'h00, "");
    idle();
    @(negedge clk); chk("R10 irq low, nothing pending", {31'd0, irq}, 32'd0);
    @(posedge clk); #1;
    tx_level = 8'd1;
    idle();
    op(1'b0, 6'h04, 8'h00, 1'b1, 8'h00, "R6 level equal to watermark");
    tx_level = 8'd0;
    idle();
    op(1'b0, 6'h04, 8'h00, 1'b1, 8'h04, "R6 level below watermark");
    @(negedge clk); chk("R10 irq on masked-in overwater", {31'd0, irq}, 32'd1);
    @(posedge clk); #1;
    op(1'b1, 6'h0C, 8'h04, 1'b0, 8'h00, "");
    @(negedge clk); chk("R10 irq after disable", {31'd0, irq}, 32'd0);
    @(posedge clk); #1;
    op(1'b1, 6'h04, 8'h7F, 1'b0, 8'h00, "");
    tx_level = 8'd5;

    // R5 mode fault
    mode_fault = 1'b1; idle(); mode_fault = 1'b0;
    op(1'b0, 6'h04, 8'h00, 1'b1, 8'h02, "R5 mode fault latched");
    @(negedge clk); chk("R10 irq on mode fault", {31'd0, irq}, 32'd1);
    @(posedge clk); #1;
    op(1'b1, 6'h04, 8'h02, 1'b0, 8'h00, "");
    op(1'b0, 6'h04, 8'h00, 1'b1, 8'h00, "R8 mode fault cleared");
    mode_fault = 1'b1; idle();
    op(1'b1, 6'h04, 8'h02, 1'b0, 8'h00, "");
    op(1'b0, 6'h04, 8'h00, 1'b1, 8'h00, "R5 held fault not relatched");
    mode_fault = 1'b0; idle();

    // R9 set and clear in the same cycle
    mode_fault = 1'b1;
    op(1'b1, 6'h04, 8'h02, 1'b0, 8'h00, "");
    mode_fault = 1'b0;
    op(1'b0, 6'h04, 8'h00, 1'b1, 8'h02, "R9 set wins over clear");

    // R12 pop strobe
    reg_rd = 1'b1; reg_addr = 6'h20;
    @(negedge clk); chk("R12 rx_pop on data read", {31'd0, rx_pop}, 32'd1);
    @(posedge clk); #1;
    reg_addr = 6'h04;
    @(negedge clk); chk("R12 rx_pop on other read", {31'd0, rx_pop}, 32'd0);
    @(posedge clk); #1;
    idle();
    finish_run();
  end
endmodule